// File: doc/BRIEF.md
# FPGA Configuration Sequencing Controller

This controller steps a programmable target fabric through its configuration lifecycle. Software writes a control word that enables the controller and selects the chip-enable level, a held-reset request, the clock-to-data ratio, the data-transfer enable and the data width. The controller decodes that word into target drive lines. It also runs a phase machine that follows the target from power-up, through reset and configuration, then initialization, and into user mode.

The target reports progress on two inputs. One is a done line. The other is an active-high status line. After configuration succeeds and software clears the data-transfer enable, the controller issues a fixed number of extra initialization clocks and then declares user mode. A status word gives software the coded phase and a synchronized copy of the external mode-select pins. Software reads this word through a small word-wide register port that answers one cycle after the request.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After synchronous reset the phase is power-up (code 0) and the control word reads 0. The drive outputs are inactive: tgt_ncfg_n=1, tgt_nce_n=1, tgt_xfer_en=0, tgt_ratio=0, tgt_wide=0, tgt_xclk_en=0.
- R2: The control word sits at offset 0x4. Bit 0 is enable, bit 1 is chip-enable (active low), bit 2 is hold-reset, bits [7:6] are the ratio, bit 8 is the transfer enable and bit 9 is the width (1 = 32-bit). Only these bits are stored, and a full-word write is taken while wr_valid and wr_ready are high. wr_ready is always 1. A read returns rd_data one cycle after rd_valid. Writes to the status offset 0x0, or to any other offset, change nothing.
- R3: Status bits [7:3] show mode_pins after passing through SYNC_STAGES flops. Status bits [2:0] show the phase code: 0 power-up, 1 reset, 2 configuration, 3 initialization, 4 user, 5 unknown.
- R4: While enable is 0, all drive outputs are held inactive as listed in R1, and the phase does not change.
- R5: While enable is 1, the outputs follow the control word: tgt_ncfg_n is the inverse of hold-reset, tgt_nce_n follows bit 1, tgt_xfer_en follows bit 8, tgt_ratio follows bits [7:6] and tgt_wide follows bit 9.
- R6: With enable and hold-reset both set, the phase becomes reset on the next cycle from any phase. It stays in reset while hold-reset remains set.
- R7: When hold-reset is cleared after having been set, the phase moves from reset to configuration.
- R8: In configuration, a low tgt_status sends the phase back to reset. The phase then stays in reset until software sets and then clears hold-reset again.
- R9: In configuration, tgt_done and tgt_status both high mark success. Once success is marked and the transfer enable is 0, the phase enters initialization. tgt_xclk_en is high for exactly EXTRA_CLKS cycles, and then the phase becomes user. While the transfer enable stays 1, the phase remains configuration.
- R10: A read of an offset other than 0x0 or 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept (always high) |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write word |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read word, one cycle after request |
| mode_pins | input | MSEL_W | External mode-select pins |
| tgt_done | input | 1 | Target configuration done |
| tgt_status | input | 1 | Target status, high when healthy |
| tgt_ncfg_n | output | 1 | Target configuration reset, active low |
| tgt_nce_n | output | 1 | Target chip enable, active low |
| tgt_xfer_en | output | 1 | Configuration data transfer enable |
| tgt_ratio | output | 2 | Clock-to-data ratio code (x1,x2,x4,x8) |
| tgt_wide | output | 1 | Data width select, 1 = 32-bit |
| tgt_xclk_en | output | 1 | Extra initialization clocks active |

## Verification
The assertions assume that tgt_status stays high in configuration unless a failure is meant. They also assume that reads and writes never overlap in one cycle in a way that depends on ordering. The bench holds tgt_status high, except in the single directed failure step. It lowers tgt_done again after success so that the latched success path is exercised. It issues register accesses one at a time from tasks. The random phase writes any control word, including hold-reset and enable, and checks only the register readback, the synchronized pins and the decoded drive lines. No phase expectation depends on random history.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int REG_W    = 32;
    localparam int OFS_STAT = 0;
    localparam int OFS_CTL  = 4;
    localparam logic [REG_W-1:0] CTL_MASK = 32'h0000_03C7;

    typedef enum logic [2:0] {
        PH_PWRUP   = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    typedef struct packed {
        logic       wide;
        logic       xfer_en;
        logic [1:0] ratio;
        logic       hold_rst;
        logic       nce;
        logic       enable;
    } ctl_s;

    typedef struct packed {
        logic       ncfg_n;
        logic       nce_n;
        logic       xfer_en;
        logic [1:0] ratio;
        logic       wide;
    } drive_s;

    function automatic ctl_s ctl_unpack(input logic [REG_W-1:0] w);
        ctl_s c;
        c.enable   = w[0];
        c.nce      = w[1];
        c.hold_rst = w[2];
        c.ratio    = w[7:6];
        c.xfer_en  = w[8];
        c.wide     = w[9];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_s c);
        logic [REG_W-1:0] w;
        w      = '0;
        w[0]   = c.enable;
        w[1]   = c.nce;
        w[2]   = c.hold_rst;
        w[7:6] = c.ratio;
        w[8]   = c.xfer_en;
        w[9]   = c.wide;
        return w;
    endfunction

    function automatic drive_s drive_of(input ctl_s c);
        drive_s d;
        d.ncfg_n  = c.enable ? ~c.hold_rst : 1'b1;
        d.nce_n   = c.enable ? c.nce : 1'b1;
        d.xfer_en = c.enable & c.xfer_en;
        d.ratio   = c.enable ? c.ratio : 2'b00;
        d.wide    = c.enable & c.wide;
        return d;
    endfunction

endpackage

// File: rtl/cfg_seq_sync.sv
module cfg_seq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
            end else if (g == 0) begin
                stage_q[g] <= din;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_seq_regs.sv
module cfg_seq_regs
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  stat_word,
    output ctl_s              ctl,
    output logic [REG_W-1:0]  rd_data
);
    ctl_s             ctl_q;
    logic [REG_W-1:0] rd_q;
    logic [REG_W-1:0] rd_mux;

    assign wr_ready = 1'b1;
    assign ctl      = ctl_q;
    assign rd_data  = rd_q;

    always_comb begin
        if (rd_addr == ADDR_W'(OFS_STAT))     rd_mux = stat_word;
        else if (rd_addr == ADDR_W'(OFS_CTL)) rd_mux = ctl_pack(ctl_q);
        else                                  rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            rd_q  <= '0;
        end else begin
            if (wr_valid && wr_ready && wr_addr == ADDR_W'(OFS_CTL))
                ctl_q <= ctl_unpack(wr_data);
            if (rd_valid)
                rd_q <= rd_mux;
        end
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int EXTRA_CLKS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  ctl_s   ctl,
    input  logic   tgt_done,
    input  logic   tgt_status,
    output phase_e phase,
    output logic   xclk_en
);
    localparam int CNT_W = $clog2(EXTRA_CLKS + 1);

    phase_e     phase_q;
    logic       armed_q;
    logic       ok_q;
    logic [CNT_W-1:0] cnt_q;

    assign phase   = phase_q;
    assign xclk_en = ctl.enable && (phase_q == PH_INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PWRUP;
            armed_q <= 1'b0;
            ok_q    <= 1'b0;
            cnt_q   <= '0;
        end else if (ctl.enable) begin
            if (ctl.hold_rst) begin
                phase_q <= PH_RESET;
                armed_q <= 1'b1;
                ok_q    <= 1'b0;
                cnt_q   <= '0;
            end else begin
                case (phase_q)
                    PH_PWRUP, PH_USER: ;
                    PH_RESET: begin
                        if (armed_q) begin
                            phase_q <= PH_CONFIG;
                            armed_q <= 1'b0;
                            ok_q    <= 1'b0;
                        end
                    end
                    PH_CONFIG: begin
                        if (!tgt_status) begin
                            phase_q <= PH_RESET;
                        end else begin
                            if (tgt_done) ok_q <= 1'b1;
                            if ((ok_q || tgt_done) && !ctl.xfer_en) begin
                                phase_q <= PH_INIT;
                                cnt_q   <= '0;
                            end
                        end
                    end
                    PH_INIT: begin
                        if (cnt_q == CNT_W'(EXTRA_CLKS - 1)) phase_q <= PH_USER;
                        else                                 cnt_q   <= cnt_q + 1'b1;
                    end
                    default: phase_q <= PH_UNKNOWN;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MSEL_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int EXTRA_CLKS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [MSEL_W-1:0] mode_pins,
    input  logic              tgt_done,
    input  logic              tgt_status,
    output logic              tgt_ncfg_n,
    output logic              tgt_nce_n,
    output logic              tgt_xfer_en,
    output logic [1:0]        tgt_ratio,
    output logic              tgt_wide,
    output logic              tgt_xclk_en
);
    localparam int PAD_W = REG_W - MSEL_W - 3;

    ctl_s              ctl_q;
    phase_e            phase_q;
    drive_s            drv;
    logic [MSEL_W-1:0] msel_q;
    logic [REG_W-1:0]  stat_word;

    cfg_seq_sync #(.WIDTH(MSEL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(mode_pins), .dout(msel_q)
    );

    cfg_seq_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .stat_word(stat_word),
        .ctl(ctl_q), .rd_data(rd_data)
    );

    cfg_seq_fsm #(.EXTRA_CLKS(EXTRA_CLKS)) i_fsm (
        .clk(clk), .rst(rst), .ctl(ctl_q),
        .tgt_done(tgt_done), .tgt_status(tgt_status),
        .phase(phase_q), .xclk_en(tgt_xclk_en)
    );

    assign stat_word   = {{PAD_W{1'b0}}, msel_q, phase_q};
    assign drv         = drive_of(ctl_q);
    assign tgt_ncfg_n  = drv.ncfg_n;
    assign tgt_nce_n   = drv.nce_n;
    assign tgt_xfer_en = drv.xfer_en;
    assign tgt_ratio   = drv.ratio;
    assign tgt_wide    = drv.wide;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
    parameter int ADDR_W     = 4,
    parameter int EXTRA_CLKS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              hold_rst,
    input logic [2:0]        phase,
    input logic              tgt_status,
    input logic              tgt_ncfg_n,
    input logic              tgt_nce_n,
    input logic              tgt_xfer_en,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data
);
    localparam int RUN_W = $clog2(EXTRA_CLKS + 2);
    logic [RUN_W-1:0] init_run;

    always_ff @(posedge clk) begin
        if (rst || phase != 3'd3)      init_run <= '0;
        else if (enable)               init_run <= init_run + 1'b1;
    end

    p_pull_forces_reset_r6: assert property (@(posedge clk) disable iff (rst)
        enable && hold_rst |=> phase == 3'd1);

    p_disabled_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(phase));

    p_disabled_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        !enable |-> tgt_ncfg_n && tgt_nce_n && !tgt_xfer_en);

    p_fail_to_reset_r8: assert property (@(posedge clk) disable iff (rst)
        enable && !hold_rst && phase == 3'd2 && !tgt_status |=> phase == 3'd1);

    p_user_via_init_r9: assert property (@(posedge clk) disable iff (rst)
        phase != 3'd4 && phase != 3'd3 |=> phase != 3'd4);

    p_init_len_r9: assert property (@(posedge clk) disable iff (rst)
        init_run <= RUN_W'(EXTRA_CLKS));

    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_addr == '0 |=> rd_data[2:0] == $past(phase));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.ADDR_W(ADDR_W), .EXTRA_CLKS(EXTRA_CLKS)) i_chk (
    .clk(clk), .rst(rst),
    .enable(ctl_q.enable), .hold_rst(ctl_q.hold_rst), .phase(phase_q),
    .tgt_status(tgt_status), .tgt_ncfg_n(tgt_ncfg_n), .tgt_nce_n(tgt_nce_n),
    .tgt_xfer_en(tgt_xfer_en), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_cfg_seq_ctrl.sv
module test_cfg_seq_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 4;
    localparam int MSEL_W      = 5;
    localparam int SYNC_STAGES = 2;
    localparam int EXTRA_CLKS  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0, rd_valid = 1'b0;
    logic wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [MSEL_W-1:0] mode_pins = '0;
    logic tgt_done = 1'b0, tgt_status = 1'b1;
    logic tgt_ncfg_n, tgt_nce_n, tgt_xfer_en, tgt_wide, tgt_xclk_en;
    logic [1:0] tgt_ratio;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_seq_ctrl #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W), .SYNC_STAGES(SYNC_STAGES),
                   .EXTRA_CLKS(EXTRA_CLKS)) i_cfg_seq_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .mode_pins(mode_pins), .tgt_done(tgt_done), .tgt_status(tgt_status),
        .tgt_ncfg_n(tgt_ncfg_n), .tgt_nce_n(tgt_nce_n), .tgt_xfer_en(tgt_xfer_en),
        .tgt_ratio(tgt_ratio), .tgt_wide(tgt_wide), .tgt_xclk_en(tgt_xclk_en)
    );

    function automatic logic [31:0] exp_ctl(input logic [31:0] w);
        return w & 32'h0000_03C7;
    endfunction

    // {ncfg_n, nce_n, xfer_en, ratio[1:0], wide}
    function automatic logic [5:0] exp_drv(input logic [31:0] w);
        logic en;
        en = w[0];
        return en ? {~w[2], w[1], w[8], w[7:6], w[9]} : 6'b110000;
    endfunction

    function automatic logic [5:0] got_drv();
        return {tgt_ncfg_n, tgt_nce_n, tgt_xfer_en, tgt_ratio, tgt_wide};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        rd_valid = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int xc;
        void'($urandom(32'd4242));
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);

        // R1 reset state
        check("R1 drive", {26'd0, got_drv()}, {26'd0, 6'b110000});
        check("R1 xclk", {31'd0, tgt_xclk_en}, 32'd0);
        rd(4'h0, v); check("R1 status", v, 32'd0);
        rd(4'h4, v); check("R1 control", v, 32'd0);
        check("R2 ready", {31'd0, wr_ready}, 32'd1);

        // R4 disabled: hold-reset without enable has no effect
        wr(4'h4, 32'h0000_0004);
        check("R4 drive", {26'd0, got_drv()}, {26'd0, 6'b110000});
        rd(4'h0, v); check("R4 phase frozen", {29'd0, v[2:0]}, 32'd0);

        // R6 enter reset
        wr(4'h4, 32'h0000_0005);
        check("R5 ncfg low", {31'd0, tgt_ncfg_n}, 32'd0);
        rd(4'h0, v); check("R6 reset", {29'd0, v[2:0]}, 32'd1);
        idle(3);
        rd(4'h0, v); check("R6 stays reset", {29'd0, v[2:0]}, 32'd1);

        // R7 release to configuration
        wr(4'h4, 32'h0000_0001);
        rd(4'h0, v); check("R7 config", {29'd0, v[2:0]}, 32'd2);

        // R8 failure
        @(negedge clk); tgt_status = 1'b0;
        idle(1);
        @(negedge clk); tgt_status = 1'b1;
        rd(4'h0, v); check("R8 back to reset", {29'd0, v[2:0]}, 32'd1);
        idle(4);
        rd(4'h0, v); check("R8 waits for pulse", {29'd0, v[2:0]}, 32'd1);

        // R9 success with transfer enabled
        wr(4'h4, 32'h0000_0105);
        wr(4'h4, 32'h0000_0101);
        rd(4'h0, v); check("R7 config again", {29'd0, v[2:0]}, 32'd2);
        check("R5 xfer on", {31'd0, tgt_xfer_en}, 32'd1);
        @(negedge clk); tgt_done = 1'b1;
        idle(2);
        @(negedge clk); tgt_done = 1'b0;
        rd(4'h0, v); check("R9 held in config", {29'd0, v[2:0]}, 32'd2);
        wr(4'h4, 32'h0000_0001);
        xc = 0;
        for (int i = 0; i < 12; i++) begin
            if (tgt_xclk_en) xc++;
            idle(1);
        end
        check("R9 extra clocks", xc, EXTRA_CLKS);
        rd(4'h0, v); check("R9 user", {29'd0, v[2:0]}, 32'd4);

        // R4 freeze in user mode, R6 reset from user
        wr(4'h4, 32'h0000_0004);
        idle(2);
        rd(4'h0, v); check("R4 frozen user", {29'd0, v[2:0]}, 32'd4);
        wr(4'h4, 32'h0000_0005);
        rd(4'h0, v); check("R6 reset from user", {29'd0, v[2:0]}, 32'd1);

        // R2 write to status offset ignored, R10 unmapped read
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2 status not writable", {29'd0, v[2:0]}, 32'd1);
        rd(4'h4, v); check("R2 control kept", v, 32'h0000_0005);
        rd(4'h8, v); check("R10 unmapped", v, 32'd0);

        // random control words and pins
        for (int k = 0; k < 30; k++) begin
            logic [31:0] w;
            logic [MSEL_W-1:0] p;
            w = $urandom;
            p = MSEL_W'($urandom);
            @(negedge clk); mode_pins = p;
            wr(4'h4, w);
            wr(4'hC, ~w);
            idle(SYNC_STAGES + 1);
            rd(4'h4, v); check("R2 control readback", v, exp_ctl(w));
            rd(4'h0, v); check("R3 pins", {27'd0, v[7:3]}, {27'd0, p});
            check("R5 drive", {26'd0, got_drv()}, {26'd0, exp_drv(w)});
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule